// File: doc/BRIEF.md
# Serial Bit-Pattern Detector

This block watches a one-bit serial stream and raises a registered, one-cycle hit flag whenever the most recently accepted bits equal a programmed pattern. A bit is accepted only on a cycle where its valid strobe is high. On any other cycle the bit is dropped and the stored history does not move. Because of this, a stream that arrives with gaps is matched exactly like a dense one.

The pattern can be from 1 to `MAX_LEN` bits long. Each position has a don't-care bit in a mask, so windows with fixed bits at the ends and free bits in the middle can be recognised. A mode input picks one of two restart rules after a hit. In overlapping mode the tail of one match may begin the next match. In non-overlapping mode the history and the fill count are cleared after a hit, so no bit is counted twice.

Configuration is held steady for the length of a stream. A new configuration is applied across a reset.

Top module: `serial_pattern_det`

## Requirements
- R1: A bit on `bit_in` enters the history only on a cycle where `bit_vld` is 1. On a cycle where `bit_vld` is 0 the bit is discarded, the history and fill count hold, and `hit_o` is 0 on the following cycle.
- R2: `hit_o` goes high on the clock cycle after the edge that accepts the bit completing a match, and it stays high for exactly one cycle per match. It is never high after a cycle whose `bit_vld` was 0.
- R3: Comparison window: window bit 0 is the bit being accepted now, and window bit k is the bit accepted k valid bits earlier. `pat_i[len_i-1]` is the oldest pattern bit and `pat_i[0]` is the newest.
- R4: When `dc_mask[i]` is 1, window position i is excluded from the comparison. For example, with length 9, pattern 011xxx110 and `dc_mask` bits 5..3 set, any 9-bit window starting 011 and ending 110 matches.
- R5: Only pattern and mask bits with an index below `len_i` take part in the comparison. Higher bits of `pat_i` and `dc_mask` have no effect.
- R6: A `len_i` of 0, or any value above `MAX_LEN`, never produces a hit.
- R7: No hit is reported until at least `len_i` valid bits have been accepted since reset, or since the last non-overlapping clear.
- R8: With `ovl_mode`=1 (overlapping), bits of one match can be reused by the next. Pattern 1011 on the stream 10110111 gives two hits.
- R9: With `ovl_mode`=0 (non-overlapping), a hit clears the history and the fill count, so the next match needs `len_i` fresh valid bits. Pattern 10111 on 101110111 gives one hit, where overlapping mode gives two.
- R10: `rst_n` low asynchronously clears the history, the fill count and `hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when `bit_in` is to be accepted |
| pat_i | input | MAX_LEN | Pattern, oldest bit at index `len_i-1` |
| dc_mask | input | MAX_LEN | Per-position don't-care, 1 = ignore |
| len_i | input | LEN_W | Pattern length, 1 to MAX_LEN |
| ovl_mode | input | 1 | 1 = overlapping, 0 = non-overlapping |
| hit_o | output | 1 | Registered one-cycle match flag |

## Verification
The checker keeps its own count of accepted bits. On every cycle it checks four things: a hit always follows an accepted bit, no hit comes before enough bits have been accepted, no hit ever appears with an out-of-range length, and in non-overlapping mode each hit is separated from the previous one by at least a full pattern's worth of fresh valid bits. The assertions cannot tell whether a given window should have matched: correct bit order, the effect of don't-care positions, ignored high pattern bits and the exact hit count for overlapping streams. Those are shown only by the bench. It replays swept configurations and gapped streams against an arithmetic model of the window, and it runs the specific example streams named in the requirements.

// File: rtl/sp_pkg.sv
package sp_pkg;

    // Restart rule applied after a successful comparison.
    typedef enum logic {
        SP_RESTART_CLEAR = 1'b0,
        SP_RESTART_SLIDE = 1'b1
    } sp_restart_e;

endpackage

// File: rtl/sp_len_decode.sv
// Turns the programmed length into a per-position "inside window" vector
// and a flag telling whether the length is usable at all.
module sp_len_decode #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [LEN_W-1:0]   len_i,
    output logic [MAX_LEN-1:0] in_win_o,
    output logic               len_ok_o
);

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_pos
        assign in_win_o[i] = (len_i > LEN_W'(i));
    end

    assign len_ok_o = (len_i != '0) && (len_i <= LEN_W'(MAX_LEN));

endmodule

// File: rtl/sp_window_cmp.sv
// Masked equality between the candidate window and the pattern.
module sp_window_cmp #(
    parameter int MAX_LEN = 16
) (
    input  logic [MAX_LEN-1:0] window_i,
    input  logic [MAX_LEN-1:0] pat_i,
    input  logic [MAX_LEN-1:0] dc_i,
    input  logic [MAX_LEN-1:0] in_win_i,
    output logic               equal_o
);

    logic [MAX_LEN-1:0] miss;

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
        // A position counts only when inside the length and not masked.
        assign miss[i] = in_win_i[i] & ~dc_i[i] & (window_i[i] ^ pat_i[i]);
    end

    assign equal_o = ~|miss;

endmodule

// File: rtl/sp_fill_gate.sv
// Decides whether enough bits have been gathered for the candidate window
// (stored bits plus the one arriving now) to span the programmed length.
module sp_fill_gate #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [LEN_W-1:0] fill_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             ready_o,
    output logic [LEN_W-1:0] fill_inc_o
);

    localparam logic [LEN_W:0] ONE = (LEN_W + 1)'(1);

    assign ready_o    = ({1'b0, fill_i} + ONE) >= {1'b0, len_i};
    assign fill_inc_o = (fill_i == LEN_W'(MAX_LEN)) ? fill_i : fill_i + LEN_W'(1);

endmodule

// File: rtl/serial_pattern_det.sv
module serial_pattern_det #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    input  logic               bit_vld,
    input  logic [MAX_LEN-1:0] pat_i,
    input  logic [MAX_LEN-1:0] dc_mask,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               ovl_mode,
    output logic               hit_o
);
    import sp_pkg::*;

    // The arriving bit supplies window position 0, so only MAX_LEN-1
    // earlier bits need storing.
    localparam int HIST_W = MAX_LEN - 1;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [LEN_W-1:0]  fill;
        logic              hit;
    } det_state_t;

    det_state_t st_d, st_q;

    logic [MAX_LEN-1:0] window;
    logic [MAX_LEN-1:0] in_win;
    logic               len_ok;
    logic               equal;
    logic               ready;
    logic [LEN_W-1:0]   fill_inc;
    logic               fire;
    sp_restart_e        restart;

    assign window  = {st_q.hist, bit_in};
    assign restart = sp_restart_e'(ovl_mode);

    sp_len_decode #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
        .len_i    (len_i),
        .in_win_o (in_win),
        .len_ok_o (len_ok)
    );

    sp_window_cmp #(.MAX_LEN(MAX_LEN)) u_cmp (
        .window_i (window),
        .pat_i    (pat_i),
        .dc_i     (dc_mask),
        .in_win_i (in_win),
        .equal_o  (equal)
    );

    sp_fill_gate #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_fill (
        .fill_i     (st_q.fill),
        .len_i      (len_i),
        .ready_o    (ready),
        .fill_inc_o (fill_inc)
    );

    assign fire = len_ok & ready & equal;

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        if (bit_vld) begin
            st_d.hit = fire;
            if (fire && restart == SP_RESTART_CLEAR) begin
                st_d.hist = '0;
                st_d.fill = '0;
            end else begin
                st_d.hist = window[HIST_W-1:0];
                st_d.fill = fill_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = st_q.hit;

endmodule

// File: rtl/sp_detect_chk.sv
module sp_detect_chk #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic             ovl_mode,
    input logic [LEN_W-1:0] len_i,
    input logic             hit_o
);

    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] tot_q;   // valid bits since reset, saturating
    logic [LEN_W-1:0] gap_q;   // valid bits after the last observed hit
    logic             seen_q;  // a hit has been observed since reset

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tot_q  <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (bit_vld && tot_q != CAP) tot_q <= tot_q + LEN_W'(1);
            if (hit_o) begin
                gap_q  <= bit_vld ? LEN_W'(1) : '0;
                seen_q <= 1'b1;
            end else if (bit_vld && gap_q != CAP) begin
                gap_q <= gap_q + LEN_W'(1);
            end
        end
    end

    // R2: a hit only follows a cycle that accepted a bit
    p_hit_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(bit_vld));

    // R6: unusable lengths stay silent
    p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == '0 || len_i > CAP) |=> !hit_o);

    // R7: enough bits accepted before the first hit
    p_fill_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (tot_q >= len_i));

    // R9: non-overlapping hits are separated by a full fresh window
    p_nonovl_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && seen_q && !ovl_mode) |-> (gap_q >= len_i));

    // R10: reset holds the flag low
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> !hit_o);

endmodule

bind serial_pattern_det sp_detect_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .ovl_mode (ovl_mode),
    .len_i    (len_i),
    .hit_o    (hit_o)
);

// File: tb/serial_pattern_det_test.sv
module serial_pattern_det_test;

    localparam int ML = 16;
    localparam int LW = $clog2(ML + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic          bit_vld = 1'b0;
    logic [ML-1:0] pat_i = '0;
    logic [ML-1:0] dc_mask = '0;
    logic [LW-1:0] len_i = '0;
    logic          ovl_mode = 1'b0;
    logic          hit_o;

    int total = 0;
    int bad = 0;
    int nhits = 0;
    bit done = 0;

    logic [ML-1:0] mh;      // model history, bit 0 newest
    int            mfill;
    logic [31:0]   rs = 32'h1BADC0DE;

    always #2 clk = ~clk;

    serial_pattern_det #(.MAX_LEN(ML), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .pat_i(pat_i), .dc_mask(dc_mask), .len_i(len_i),
        .ovl_mode(ovl_mode), .hit_o(hit_o)
    );

    function logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic logic model_hit(input logic [ML-1:0] cand, input logic v);
        int l;
        l = int'(len_i);
        if (!v || l == 0 || l > ML || mfill < l - 1) return 1'b0;
        for (int i = 0; i < l; i++)
            if (!dc_mask[i] && cand[i] != pat_i[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic v, input string tag);
        logic [ML-1:0] cand;
        logic exp;
        @(negedge clk);
        bit_in  = b;
        bit_vld = v;
        cand = {mh[ML-2:0], b};
        exp  = model_hit(cand, v);
        @(posedge clk);
        #1;
        check(tag, hit_o, exp);
        if (hit_o === 1'b1) nhits++;
        if (v) begin
            if (exp && !ovl_mode) begin
                mh = '0;
                mfill = 0;
            end else begin
                mh = cand;
                if (mfill < ML) mfill++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_vld = 1'b0;
        #1;
        check("R10 async clear", hit_o, 1'b0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mh = '0;
        mfill = 0;
        nhits = 0;
    endtask

    task automatic cfg(input logic [ML-1:0] p, input logic [ML-1:0] m,
                       input int l, input logic o);
        pat_i = p;
        dc_mask = m;
        len_i = LW'(l);
        ovl_mode = o;
        do_reset();
    endtask

    task automatic feed(input logic [31:0] bits, input int n, input string tag);
        for (int k = n - 1; k >= 0; k--) step(bits[k], 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mh = '0;
        mfill = 0;
        #1;
        check("R10 reset state", hit_o, 1'b0);

        // R8: overlapping, 1011 in 10110111 -> two hits
        cfg(16'h000B, '0, 4, 1'b1);
        feed(32'b10110111, 8, "R8 overlap");
        check_int("R8 overlap count", nhits, 2);

        // R9: non-overlapping, 10111 in 101110111 -> one hit
        cfg(16'h0017, '0, 5, 1'b0);
        feed(32'b101110111, 9, "R9 nonoverlap");
        check_int("R9 nonoverlap count", nhits, 1);
        cfg(16'h0017, '0, 5, 1'b1);
        feed(32'b101110111, 9, "R8 same stream overlap");
        check_int("R8 same stream overlap count", nhits, 2);

        // R4: 011xxx110 with middle masked
        cfg(16'h00C6, 16'h0038, 9, 1'b1);
        feed(32'b011101110, 9, "R4 dont care match");
        check_int("R4 dont care match count", nhits, 1);
        cfg(16'h00C6, 16'h0038, 9, 1'b1);
        feed(32'b010101110, 9, "R4 cared bit differs");
        check_int("R4 cared bit differs count", nhits, 0);

        // R5: junk above the length is ignored
        cfg(16'hF5AB, 16'hA500, 4, 1'b1);
        feed(32'b1011, 4, "R5 high bits ignored");
        check_int("R5 high bits ignored count", nhits, 1);

        // R6: length 0 and above max never hit
        cfg(16'hFFFF, '0, 0, 1'b1);
        feed(32'hFFFFFFFF, 20, "R6 length zero");
        check_int("R6 length zero count", nhits, 0);
        cfg(16'hFFFF, '0, ML + 1, 1'b1);
        feed(32'hFFFFFFFF, 20, "R6 length above max");
        check_int("R6 length above max count", nhits, 0);

        // R7: all-zero pattern must wait for a full window after reset
        cfg(16'h0000, '0, 4, 1'b0);
        feed(32'b000, 3, "R7 short fill");
        check_int("R7 short fill count", nhits, 0);
        feed(32'b0, 1, "R7 full fill");
        check_int("R7 full fill count", nhits, 1);
        feed(32'b000, 3, "R7 refill after clear");
        check_int("R7 refill after clear count", nhits, 1);

        // R1: invalid bits that would break 0110 are skipped
        cfg(16'h0006, '0, 4, 1'b1);
        step(1'b0, 1'b1, "R1 gated");
        step(1'b1, 1'b1, "R1 gated");
        step(1'b0, 1'b0, "R1 gated");
        step(1'b1, 1'b1, "R1 gated");
        step(1'b1, 1'b0, "R1 gated");
        step(1'b0, 1'b1, "R1 gated");
        step(1'b0, 1'b0, "R2 single pulse");
        check_int("R1 gated count", nhits, 1);

        // R10: reset mid-stream forces a fresh fill
        cfg(16'h0000, '0, 3, 1'b1);
        feed(32'b00, 2, "R10 before reset");
        do_reset();
        feed(32'b00, 2, "R10 after reset");
        check_int("R10 after reset count", nhits, 0);
        feed(32'b0, 1, "R10 refilled");
        check_int("R10 refilled count", nhits, 1);

        // R3 R2 R4 R5 R7: swept configurations with gapped, seeded streams
        for (int c = 0; c < 64; c++) begin
            logic [31:0] r;
            int l;
            r = rnd();
            l = 1 + (c % ML);
            cfg(r[ML-1:0], (c % 3 == 0) ? rnd() & rnd() : '0, l, c[0]);
            for (int s = 0; s < 40; s++) begin
                if (rnd() % 3 == 0) begin
                    for (int k = l - 1; k >= 0; k--) begin
                        while (rnd() % 4 == 0) step(rnd() % 2 == 0, 1'b0, "R3 sweep gap");
                        step(pat_i[k], 1'b1, "R3 sweep inject");
                    end
                end else begin
                    step(rnd() % 2 == 1, rnd() % 4 != 0, "R2 sweep random");
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule